// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block Memory

This block is a 4,608-bit synchronous memory with two ports, A and B, on a single clock. Each port has its own clock enable, read enable, write enable, byte enables, address and data. The read width and the write width of each port are set at elaboration. One port may therefore see the storage as, for example, 9-bit words while the other sees it as 18-bit words. The storage is one bit-linear array: word `w` of a port that is `W` bits wide covers array bits `w*W` up to `w*W+W-1`. Data written at one width can therefore be read back at another width.

The legal widths are 1, 2, 4, 8, 9, 16, 18, 32 and 36. The widths 9, 18 and 36 carry one extra bit per byte, for parity or tags. A port's depth is 4096 divided by its power-of-two width (8 for 9, 16 for 18, 32 for 36). Three organisations are selected by the `MODE` parameter:
- **Two-port read/write (0):** both ports read and write.
- **One writer, one reader (1):** port A only writes and port B only reads.
- **Two split single-port memories (2):** each port reads and writes its own half of the array.

Elaboration stops with an error for an illegal width. It also stops for a 32-bit or 36-bit port in mode 0.

Port inputs are sampled on the clock edge. Read data is available after that edge, or one edge later when `OUT_REG` is 1.

Top module: `mwr_ram`

## Requirements
- R1: While `rst` is high at a clock edge, both read outputs are cleared to zero.
- R2: A read sampled at edge k shows its data on the port output after edge k when `OUT_REG`=0, and after edge k+1 when `OUT_REG`=1.
- R3: A port of width W maps word w onto array bits w*W through w*W+W-1. The same bits read through the other port, at its own width, return the written values.
- R4: For W of 8 or more, the byte lane width L is 9 when W is 9, 18 or 36, and 8 otherwise. Byte enable bit i guards data bits i*L+L-1 down to i*L. Any combination of byte enables is allowed, including none, which writes nothing. Widths below 8 write the whole word.
- R5: A read and a write to the same address on one port, sampled at the same edge, return the old contents.
- R6: A read on one port sampled at the same edge as a write on the other port to the same bits returns the old contents. The two ports must never write overlapping words at the same edge.
- R7: With a port's clock enable low, that port neither writes, nor reads, nor changes its output.
- R8: With read enable low, a port's output holds its last value, even when the addressed bits are rewritten.
- R9: In mode 1, a write on port B and a read on port A have no effect: the array is unchanged and `dout_a` stays at its reset value of zero.
- R10: In mode 2, port A addresses the lower half and port B the upper half, and the top bit of each port's address is ignored.
- R11: In mode 0, port B writes as well as reads, and its writes are visible through port A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| ce_a | input | 1 | Port A clock enable |
| we_a | input | 1 | Port A write enable |
| re_a | input | 1 | Port A read enable |
| be_a | input | NL_A | Port A byte enables, one per lane |
| addr_a | input | AW_A | Port A word address |
| din_a | input | WIDTH_A | Port A write data |
| dout_a | output | WIDTH_A | Port A read data |
| ce_b | input | 1 | Port B clock enable |
| we_b | input | 1 | Port B write enable |
| re_b | input | 1 | Port B read enable |
| be_b | input | NL_B | Port B byte enables, one per lane |
| addr_b | input | AW_B | Port B word address |
| din_b | input | WIDTH_B | Port B write data |
| dout_b | output | WIDTH_B | Port B read data |

## Verification
The bench builds three copies of the block.
- **Copy 1:** mode 0 with 18-bit and 9-bit ports and the output register on. This brings two-lane parity byte enables, cross-width aliasing, two-edge latency, port B writes and read-versus-write ordering within reach.
- **Copy 2:** mode 1 with a 36-bit writer and a 4-bit reader and no output register. This reaches the widest four-lane shape, nibble reads that straddle lane borders, single-edge latency, and the ignored port B writes and port A reads.
- **Copy 3:** mode 2 with two 8-bit ports. This shows that the halves are separate and that the top address bit is ignored.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  localparam int MODE_TDP   = 0;
  localparam int MODE_SDP   = 1;
  localparam int MODE_SPLIT = 2;

  localparam int TOTAL_BITS = 4608;

  // power-of-two data width of a shape (extra byte bits removed)
  function automatic int pow2_w(int w);
    return (w % 9 == 0) ? (w / 9) * 8 : w;
  endfunction

  function automatic int addr_w(int w);
    return $clog2(4096 / pow2_w(w));
  endfunction

  function automatic int lane_w(int w);
    if (w < 8) return w;
    return (w % 9 == 0) ? 9 : 8;
  endfunction

  function automatic int lane_n(int w);
    return w / lane_w(w);
  endfunction

  function automatic bit legal_w(int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 9) ||
           (w == 16) || (w == 18) || (w == 32) || (w == 36);
  endfunction

  // first array bit of a word, with the half-select of split mode
  function automatic int base_of(int addr, int w, int aw, bit split, bit hi);
    int a;
    a = addr;
    if (split) begin
      a = addr % (1 << (aw - 1));
      if (hi) a = a + (1 << (aw - 1));
    end
    return a * w;
  endfunction

endpackage

// File: rtl/mwr_wmap.sv
module mwr_wmap
  import mwr_pkg::*;
#(
  parameter int W    = 8,
  parameter int MODE = MODE_TDP,
  parameter bit HI   = 1'b0,
  localparam int AW  = addr_w(W),
  localparam int LW  = lane_w(W),
  localparam int NL  = lane_n(W)
) (
  input  logic                  en,
  input  logic [AW-1:0]         addr,
  input  logic [NL-1:0]         be,
  input  logic [W-1:0]          din,
  output logic [TOTAL_BITS-1:0] mask,
  output logic [TOTAL_BITS-1:0] data
);

  always_comb begin
    int b;
    b    = base_of(int'(addr), W, AW, MODE == MODE_SPLIT, HI);
    mask = '0;
    data = '0;
    if (en) begin
      for (int l = 0; l < NL; l++) begin
        if (be[l] || (W < 8)) begin
          mask[b + l*LW +: LW] = '1;
          data[b + l*LW +: LW] = din[l*LW +: LW];
        end
      end
    end
  end

endmodule

// File: rtl/mwr_rport.sv
module mwr_rport
  import mwr_pkg::*;
#(
  parameter int W       = 8,
  parameter int MODE    = MODE_TDP,
  parameter bit HI      = 1'b0,
  parameter bit OUT_REG = 1'b0,
  localparam int AW     = addr_w(W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  logic                  rd,
  input  logic [AW-1:0]         addr,
  input  logic [TOTAL_BITS-1:0] mem,
  output logic [W-1:0]          dout
);

  logic [W-1:0] raw_q;
  int           rbase;

  always_comb rbase = base_of(int'(addr), W, AW, MODE == MODE_SPLIT, HI);

  always_ff @(posedge clk) begin
    if (rst)            raw_q <= '0;
    else if (ce && rd)  raw_q <= mem[rbase +: W];
  end

  generate
    if (OUT_REG) begin : g_oreg
      logic [W-1:0] out_q;
      always_ff @(posedge clk) begin
        if (rst)     out_q <= '0;
        else if (ce) out_q <= raw_q;
      end
      assign dout = out_q;
    end else begin : g_noreg
      assign dout = raw_q;
    end
  endgenerate

endmodule

// File: rtl/mwr_ram.sv
module mwr_ram
  import mwr_pkg::*;
#(
  parameter int MODE    = MODE_TDP,
  parameter int WIDTH_A = 18,
  parameter int WIDTH_B = 9,
  parameter bit OUT_REG = 1'b1,
  localparam int AW_A   = addr_w(WIDTH_A),
  localparam int AW_B   = addr_w(WIDTH_B),
  localparam int NL_A   = lane_n(WIDTH_A),
  localparam int NL_B   = lane_n(WIDTH_B)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce_a,
  input  logic               we_a,
  input  logic               re_a,
  input  logic [NL_A-1:0]    be_a,
  input  logic [AW_A-1:0]    addr_a,
  input  logic [WIDTH_A-1:0] din_a,
  output logic [WIDTH_A-1:0] dout_a,
  input  logic               ce_b,
  input  logic               we_b,
  input  logic               re_b,
  input  logic [NL_B-1:0]    be_b,
  input  logic [AW_B-1:0]    addr_b,
  input  logic [WIDTH_B-1:0] din_b,
  output logic [WIDTH_B-1:0] dout_b
);

  generate
    if (!legal_w(WIDTH_A) || !legal_w(WIDTH_B)) begin : g_bad_width
      $error("mwr_ram: unsupported port width");
    end
    if (MODE == MODE_TDP && (WIDTH_A >= 32 || WIDTH_B >= 32)) begin : g_bad_tdp
      $error("mwr_ram: 32/36-bit shape not allowed with two read/write ports");
    end
  endgenerate

  localparam bit A_READS  = (MODE != MODE_SDP);
  localparam bit B_WRITES = (MODE != MODE_SDP);

  logic                  wr_a, wr_b, rd_a, rd_b;
  logic [TOTAL_BITS-1:0] mask_a, mask_b, data_a, data_b;
  logic [TOTAL_BITS-1:0] mem;

  assign wr_a = ce_a && we_a;
  assign wr_b = ce_b && we_b && B_WRITES;
  assign rd_a = re_a && A_READS;
  assign rd_b = re_b;

  mwr_wmap #(.W(WIDTH_A), .MODE(MODE), .HI(1'b0)) u_wmap_a (
    .en(wr_a), .addr(addr_a), .be(be_a), .din(din_a),
    .mask(mask_a), .data(data_a)
  );

  mwr_wmap #(.W(WIDTH_B), .MODE(MODE), .HI(1'b1)) u_wmap_b (
    .en(wr_b), .addr(addr_b), .be(be_b), .din(din_b),
    .mask(mask_b), .data(data_b)
  );

  // shared bit-linear array; reads below see the pre-edge contents
  always_ff @(posedge clk) begin
    if (|(mask_a | mask_b))
      mem <= (mem & ~(mask_a | mask_b)) | data_a | data_b;
  end

  mwr_rport #(.W(WIDTH_A), .MODE(MODE), .HI(1'b0), .OUT_REG(OUT_REG)) u_rport_a (
    .clk(clk), .rst(rst), .ce(ce_a), .rd(rd_a), .addr(addr_a),
    .mem(mem), .dout(dout_a)
  );

  mwr_rport #(.W(WIDTH_B), .MODE(MODE), .HI(1'b1), .OUT_REG(OUT_REG)) u_rport_b (
    .clk(clk), .rst(rst), .ce(ce_b), .rd(rd_b), .addr(addr_b),
    .mem(mem), .dout(dout_b)
  );

endmodule

// File: rtl/mwr_ram_chk.sv
module mwr_ram_chk
  import mwr_pkg::*;
#(
  parameter int MODE    = MODE_TDP,
  parameter int WIDTH_A = 18,
  parameter int WIDTH_B = 9,
  localparam int AW_A   = addr_w(WIDTH_A),
  localparam int AW_B   = addr_w(WIDTH_B)
) (
  input logic               clk,
  input logic               rst,
  input logic               ce_a,
  input logic               we_a,
  input logic               re_a,
  input logic [AW_A-1:0]    addr_a,
  input logic [WIDTH_A-1:0] dout_a,
  input logic               ce_b,
  input logic               we_b,
  input logic               re_b,
  input logic [AW_B-1:0]    addr_b,
  input logic [WIDTH_B-1:0] dout_b
);

  int   lo_a, lo_b;
  logic both_wr, rd_a, rd_b;

  always_comb begin
    lo_a    = base_of(int'(addr_a), WIDTH_A, AW_A, MODE == MODE_SPLIT, 1'b0);
    lo_b    = base_of(int'(addr_b), WIDTH_B, AW_B, MODE == MODE_SPLIT, 1'b1);
    both_wr = ce_a && we_a && ce_b && we_b && (MODE != MODE_SDP);
    rd_a    = ce_a && re_a && (MODE != MODE_SDP);
    rd_b    = ce_b && re_b;
  end

  // R6
  collide_chk: assert property (@(posedge clk) disable iff (rst)
    !(both_wr && (lo_a <= lo_b + WIDTH_B - 1) && (lo_b <= lo_a + WIDTH_A - 1)));

  // R1
  rst_out_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dout_a == '0 && dout_b == '0));

  // R7
  ce_hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_a |=> $stable(dout_a));

  // R7
  ce_hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_b |=> $stable(dout_b));

  // R8
  rd_hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_a ##1 !rd_a) |=> $stable(dout_a));

  // R8
  rd_hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_b ##1 !rd_b) |=> $stable(dout_b));

endmodule

bind mwr_ram mwr_ram_chk #(.MODE(MODE), .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B)) u_chk (
  .clk(clk), .rst(rst),
  .ce_a(ce_a), .we_a(we_a), .re_a(re_a), .addr_a(addr_a), .dout_a(dout_a),
  .ce_b(ce_b), .we_b(we_b), .re_b(re_b), .addr_b(addr_b), .dout_b(dout_b)
);

// File: tb/sim_mwr_ram.sv
module sim_mwr_ram;
  import mwr_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  // u0: two read/write ports, 18 and 9 bits, output register on
  logic ce_a0 = 1, we_a0 = 0, re_a0 = 0, ce_b0 = 1, we_b0 = 0, re_b0 = 0;
  logic [1:0]  be_a0 = '0;  logic [0:0] be_b0 = '0;
  logic [7:0]  addr_a0 = '0; logic [8:0] addr_b0 = '0;
  logic [17:0] din_a0 = '0, dout_a0;
  logic [8:0]  din_b0 = '0, dout_b0;

  // u1: one writer (36) and one reader (4), no output register
  logic ce_a1 = 1, we_a1 = 0, re_a1 = 0, ce_b1 = 1, we_b1 = 0, re_b1 = 0;
  logic [3:0]  be_a1 = '0;  logic [0:0] be_b1 = '0;
  logic [6:0]  addr_a1 = '0; logic [9:0] addr_b1 = '0;
  logic [35:0] din_a1 = '0, dout_a1;
  logic [3:0]  din_b1 = '0, dout_b1;

  // u2: two split single-port halves, 8 bits each, no output register
  logic ce_a2 = 1, we_a2 = 0, re_a2 = 0, ce_b2 = 1, we_b2 = 0, re_b2 = 0;
  logic [0:0]  be_a2 = '0, be_b2 = '0;
  logic [8:0]  addr_a2 = '0, addr_b2 = '0;
  logic [7:0]  din_a2 = '0, dout_a2, din_b2 = '0, dout_b2;

  mwr_ram #(.MODE(MODE_TDP), .WIDTH_A(18), .WIDTH_B(9), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst(rst),
    .ce_a(ce_a0), .we_a(we_a0), .re_a(re_a0), .be_a(be_a0), .addr_a(addr_a0),
    .din_a(din_a0), .dout_a(dout_a0),
    .ce_b(ce_b0), .we_b(we_b0), .re_b(re_b0), .be_b(be_b0), .addr_b(addr_b0),
    .din_b(din_b0), .dout_b(dout_b0));

  mwr_ram #(.MODE(MODE_SDP), .WIDTH_A(36), .WIDTH_B(4), .OUT_REG(1'b0)) u1 (
    .clk(clk), .rst(rst),
    .ce_a(ce_a1), .we_a(we_a1), .re_a(re_a1), .be_a(be_a1), .addr_a(addr_a1),
    .din_a(din_a1), .dout_a(dout_a1),
    .ce_b(ce_b1), .we_b(we_b1), .re_b(re_b1), .be_b(be_b1), .addr_b(addr_b1),
    .din_b(din_b1), .dout_b(dout_b1));

  mwr_ram #(.MODE(MODE_SPLIT), .WIDTH_A(8), .WIDTH_B(8), .OUT_REG(1'b0)) u2 (
    .clk(clk), .rst(rst),
    .ce_a(ce_a2), .we_a(we_a2), .re_a(re_a2), .be_a(be_a2), .addr_a(addr_a2),
    .din_a(din_a2), .dout_a(dout_a2),
    .ce_b(ce_b2), .we_b(we_b2), .re_b(re_b2), .be_b(be_b2), .addr_b(addr_b2),
    .din_b(din_b2), .dout_b(dout_b2));

  // ---------------- scoreboard ----------------
  typedef struct {
    int          due;
    int          sel;
    logic [35:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb[$];

  function automatic logic [35:0] pick(int sel);
    case (sel)
      0: return 36'(dout_a0);
      1: return 36'(dout_b0);
      2: return dout_a1;
      3: return 36'(dout_b1);
      4: return 36'(dout_a2);
      default: return 36'(dout_b2);
    endcase
  endfunction

  function automatic void judge(int sel, logic [35:0] exp, string tag);
    logic [35:0] act;
    act   = pick(sel);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s out%0d actual=%h expected=%h", tag, sel, act, exp);
    end
  endfunction

  // driver side: read sampled at the coming edge, result due after lat more edges
  task automatic expect_rd(int sel, int lat, logic [35:0] exp, string tag);
    sb_item_t it;
    it.due = cyc + 1 + lat;
    it.sel = sel;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor side
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        judge(sb[i].sel, sb[i].exp, sb[i].tag);
        sb.delete(i);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    we_a0 = 0; re_a0 = 0; we_b0 = 0; re_b0 = 0;
    we_a1 = 0; re_a1 = 0; we_b1 = 0; re_b1 = 0;
    we_a2 = 0; re_a2 = 0; we_b2 = 0; re_b2 = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 outputs cleared by reset
    judge(0, 36'h0, "R1");
    judge(1, 36'h0, "R1");
    judge(3, 36'h0, "R1");
    judge(5, 36'h0, "R1");

    // ---- u0 ----
    we_a0 = 1; addr_a0 = 8'd5; din_a0 = 18'h1ABCD; be_a0 = 2'b11; step();
    re_a0 = 1; addr_a0 = 8'd5; expect_rd(0, 1, 36'h1ABCD, "R2");
    re_b0 = 1; addr_b0 = 9'd10; expect_rd(1, 1, 36'h1CD, "R3"); step();
    re_b0 = 1; addr_b0 = 9'd11; expect_rd(1, 1, 36'h0D5, "R3"); step();
    // R4 upper lane only
    we_a0 = 1; addr_a0 = 8'd5; din_a0 = 18'h0; be_a0 = 2'b10; step();
    re_a0 = 1; addr_a0 = 8'd5; expect_rd(0, 1, 36'h001CD, "R4"); step();
    // R4 lower lane only, then no lanes
    we_a0 = 1; addr_a0 = 8'd5; din_a0 = 18'h3FFFF; be_a0 = 2'b01; step();
    we_a0 = 1; addr_a0 = 8'd5; din_a0 = 18'h2AAAA; be_a0 = 2'b00; step();
    re_a0 = 1; addr_a0 = 8'd5; expect_rd(0, 1, 36'h001FF, "R4"); step();
    // R11 port B writes, seen through port A
    we_b0 = 1; addr_b0 = 9'd12; din_b0 = 9'h155; be_b0 = 1'b1; step();
    we_b0 = 1; addr_b0 = 9'd13; din_b0 = 9'h0AA; be_b0 = 1'b1; step();
    re_a0 = 1; addr_a0 = 8'd6; expect_rd(0, 1, 36'h15555, "R11"); step();
    // R5 same-port read during write
    we_a0 = 1; re_a0 = 1; addr_a0 = 8'd5; din_a0 = 18'h24924; be_a0 = 2'b11;
    expect_rd(0, 1, 36'h001FF, "R5"); step();
    re_a0 = 1; addr_a0 = 8'd5; expect_rd(0, 1, 36'h24924, "R5"); step();
    // R6 cross-port read during write
    we_a0 = 1; addr_a0 = 8'd6; din_a0 = 18'h0; be_a0 = 2'b11;
    re_b0 = 1; addr_b0 = 9'd12; expect_rd(1, 1, 36'h155, "R6"); step();
    re_b0 = 1; addr_b0 = 9'd12; expect_rd(1, 1, 36'h000, "R6"); step();
    // R7 clock enable low blocks a write and a read
    ce_a0 = 0; we_a0 = 1; re_a0 = 1; addr_a0 = 8'd6; din_a0 = 18'h3FFFF; step();
    ce_a0 = 1;
    re_a0 = 1; addr_a0 = 8'd6; expect_rd(0, 1, 36'h00000, "R7"); step();
    re_a0 = 1; addr_a0 = 8'd5; expect_rd(0, 1, 36'h24924, "R7"); step();
    // R8 rewrite the bits with reads off; output holds
    step(); step();
    we_a0 = 1; addr_a0 = 8'd5; din_a0 = 18'h0; be_a0 = 2'b11; step();
    step(); step();
    judge(0, 36'h24924, "R8");

    // ---- u1 ----
    we_a1 = 1; addr_a1 = 7'd3; din_a1 = 36'h987654321; be_a1 = 4'b1111; step();
    re_b1 = 1; addr_b1 = 10'd27; expect_rd(3, 0, 36'h1, "R3"); step();
    re_b1 = 1; addr_b1 = 10'd35; expect_rd(3, 0, 36'h9, "R2"); step();
    we_a1 = 1; addr_a1 = 7'd3; din_a1 = 36'h0; be_a1 = 4'b0100; step();
    re_b1 = 1; addr_b1 = 10'd31; expect_rd(3, 0, 36'h1, "R4"); step();
    re_b1 = 1; addr_b1 = 10'd30; expect_rd(3, 0, 36'h4, "R4"); step();
    re_b1 = 1; addr_b1 = 10'd32; expect_rd(3, 0, 36'h0, "R4"); step();
    // R9 port B write and port A read ignored
    we_b1 = 1; addr_b1 = 10'd27; din_b1 = 4'hF; be_b1 = 1'b1;
    re_a1 = 1; addr_a1 = 7'd3; step();
    re_b1 = 1; addr_b1 = 10'd27; expect_rd(3, 0, 36'h1, "R9"); step();
    judge(2, 36'h0, "R9");

    // ---- u2 ----
    we_a2 = 1; addr_a2 = 9'd7; din_a2 = 8'h3C; be_a2 = 1'b1;
    we_b2 = 1; addr_b2 = 9'd7; din_b2 = 8'hC3; be_b2 = 1'b1; step();
    re_a2 = 1; addr_a2 = 9'd7; expect_rd(4, 0, 36'h3C, "R10");
    re_b2 = 1; addr_b2 = 9'd7; expect_rd(5, 0, 36'hC3, "R10"); step();
    we_a2 = 1; addr_a2 = 9'd263; din_a2 = 8'h11; be_a2 = 1'b1; step();
    re_a2 = 1; addr_a2 = 9'd7; expect_rd(4, 0, 36'h11, "R10");
    re_b2 = 1; addr_b2 = 9'd7; expect_rd(5, 0, 36'hC3, "R10"); step();

    repeat (4) step();
    while (sb.size() != 0) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL %s out%0d actual=missing expected=%h", sb[0].tag, sb[0].sel, sb[0].exp);
      void'(sb.pop_front());
    end
    done = 1'b1;
    finish_run();
  end

endmodule